// File: doc/BRIEF.md
# Delayed Write Retry Arbiter

This block sits on the target side of a bus bridge and decides, for each write that an initiator presents, whether the write is given a target retry or is accepted. It keeps a small delayed-transaction queue. Each slot holds an address, a command, a lock flag and a progress state: queued, issued to the far bus, or completed. A new write that matches no slot is placed in the queue and retried. The initiator then repeats the same write until its slot has completed and is the oldest slot in the queue. That repeat is accepted and frees the slot.

Two lock conditions are checked before any queue decision. The first is a locked sequence travelling across the bridge. The second is the target bus being held locked. The far-bus master tells the arbiter when a slot is issued and when its response arrives; both are reported by slot index. Completions are handed back strictly in the order the slots were filled. Moving the data and running the far-bus master are outside this block.

Top module: `dwq_retry_arbiter`

## Requirements
- R1: A write that matches no occupied slot, while the queue has room and no lock condition applies, is retried. In the same cycle it is written into the queue at the tail slot: `enqStrobe` pulses and `enqIdx` gives that slot. Slots fill in ascending index order and wrap from DEPTH-1 to 0.
- R2: A write with the same address and command as a slot in the queued or issued state is retried. No new slot is taken, so duplicates never enter the queue.
- R3: A write that matches a completed slot which is not the oldest occupied slot is retried, and the slot is kept.
- R4: A write that matches no slot while all DEPTH slots are occupied is retried and is not enqueued.
- R5: While `lockSeqActive` is high, a write with `reqLocked` low is retried. Nothing is enqueued or freed. This check takes priority over every queue rule.
- R6: While `targetBusLocked` is high, a write with `reqLocked` high is retried. Nothing is enqueued or freed. This check takes priority over every queue rule.
- R7: A write that matches the completed, oldest slot is accepted (`decRetry` low), provided R5 and R6 do not apply. That slot is freed in the same cycle.
- R8: The decision is registered. `decValid`, `decRetry` and `enqStrobe` reflect the request sampled at the previous clock edge. `decValid` is low in any cycle after an edge where no request was presented.
- R9: After reset the queue is empty, and `decValid`, `decRetry`, `enqStrobe` and `complReady` are low.
- R10: `issueValid` moves a slot from queued to issued only. `rspValid` moves a slot from issued to completed only. Either strobe aimed at a slot in any other state has no effect.
- R11: `complReady` is high exactly when the oldest occupied slot has completed, and `complIdx` names that slot. Completions therefore become ready in enqueue order, whatever order the responses arrive in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A write request is presented this cycle |
| reqAddr | input | ADDR_W | Write address |
| reqCmd | input | CMD_W | Write command code |
| reqLocked | input | 1 | The write is part of a locked sequence |
| lockSeqActive | input | 1 | A locked sequence is crossing the bridge |
| targetBusLocked | input | 1 | The target bus is locked |
| issueValid | input | 1 | The far-bus master has started a slot |
| issueIdx | input | IDX_W | Slot started |
| rspValid | input | 1 | A target response arrived for a slot |
| rspIdx | input | IDX_W | Slot that received its response |
| decValid | output | 1 | Registered decision is valid |
| decRetry | output | 1 | Registered decision: 1 retry, 0 accept |
| enqStrobe | output | 1 | The last request was written into the queue |
| enqIdx | output | IDX_W | Slot used by the last enqueue |
| complReady | output | 1 | The oldest slot has completed |
| complIdx | output | IDX_W | Index of the oldest slot |

## Verification
The bench builds the arbiter with DEPTH=4, ADDR_W=8 and CMD_W=4. With four slots, filling the queue, overflowing it and wrapping the tail and head pointers past index 3 all take only a few requests. The bench sweeps all eight combinations of the request lock flag and the two bus lock states against queues at several fill levels. It returns responses in reverse and in forward order so that ordering at the head is exercised. Expected decisions come from a small slot model in the bench that applies the requirement rules in priority order.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_QUEUED = 2'd1,
    SLOT_ISSUED = 2'd2,
    SLOT_DONE   = 2'd3
  } slotState_t;

  typedef struct packed {
    logic enq;
    logic freeHead;
  } dwqStrobe_t;
endpackage

// File: rtl/dwq_store.sv
module dwq_store
  import dwq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic              reqLocked,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueIdx,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspIdx,
  output logic              matchHit,
  output logic [IDX_W-1:0]  matchIdx,
  output slotState_t        matchState,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic              queueFull,
  output logic              headDone
);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [CMD_W-1:0]  slotCmd  [DEPTH];
  logic              slotLock [DEPTH];
  slotState_t        slotSt   [DEPTH];
  logic [IDX_W-1:0]  headPtr, tailPtr;
  logic [IDX_W:0]    count;
  logic [DEPTH-1:0]  hitVec;

  // Per-slot comparators for duplicate and repeat detection
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitVec[g] = (slotSt[g] != SLOT_FREE) &&
                       (slotAddr[g] == reqAddr) && (slotCmd[g] == reqCmd);
  end

  always_comb begin
    matchHit = 1'b0;
    matchIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hitVec[i] && !matchHit) begin
        matchHit = 1'b1;
        matchIdx = IDX_W'(i);
      end
    end
  end

  assign matchState = slotSt[matchIdx];
  assign headIdx    = headPtr;
  assign tailIdx    = tailPtr;
  assign queueFull  = (count == FULL_CNT);
  assign headDone   = (count != '0) && (slotSt[headPtr] == SLOT_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slotSt[i]   <= SLOT_FREE;
        slotAddr[i] <= '0;
        slotCmd[i]  <= '0;
        slotLock[i] <= 1'b0;
      end
    end else begin
      if (issueValid && slotSt[issueIdx] == SLOT_QUEUED)
        slotSt[issueIdx] <= SLOT_ISSUED;
      if (rspValid && slotSt[rspIdx] == SLOT_ISSUED)
        slotSt[rspIdx] <= SLOT_DONE;
      if (strb.freeHead) begin
        slotSt[headPtr] <= SLOT_FREE;
        headPtr         <= IDX_W'(headPtr + 1'b1);
      end
      if (strb.enq) begin
        slotSt[tailPtr]   <= SLOT_QUEUED;
        slotAddr[tailPtr] <= reqAddr;
        slotCmd[tailPtr]  <= reqCmd;
        slotLock[tailPtr] <= reqLocked;
        tailPtr           <= IDX_W'(tailPtr + 1'b1);
      end
      count <= count + (IDX_W+1)'(strb.enq) - (IDX_W+1)'(strb.freeHead);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.enq |-> !queueFull);

  assert_free_only_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeHead |-> headDone);

  assert_enq_grows_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enq && !strb.freeHead) |=> (count == $past(count) + 1'b1));

  assert_issue_only_queued_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && slotSt[issueIdx] == SLOT_FREE && !(strb.enq && tailPtr == issueIdx))
      |=> (slotSt[$past(issueIdx)] == SLOT_FREE));
endmodule

// File: rtl/dwq_ctrl.sv
module dwq_ctrl
  import dwq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqLocked,
  input  logic             lockSeqActive,
  input  logic             targetBusLocked,
  input  logic             matchHit,
  input  logic [IDX_W-1:0] matchIdx,
  input  slotState_t       matchState,
  input  logic [IDX_W-1:0] headIdx,
  input  logic [IDX_W-1:0] tailIdx,
  input  logic             queueFull,
  output dwqStrobe_t       strb,
  output logic             decValid,
  output logic             decRetry,
  output logic             enqStrobe,
  output logic [IDX_W-1:0] enqIdx
);
  logic lockBlock;
  logic headRepeat;

  // Lock rules outrank every queue rule
  assign lockBlock  = (!reqLocked && lockSeqActive) || (reqLocked && targetBusLocked);
  assign headRepeat = matchHit && (matchState == SLOT_DONE) && (matchIdx == headIdx);

  always_comb begin
    strb          = '0;
    strb.freeHead = reqValid && !lockBlock && headRepeat;
    strb.enq      = reqValid && !lockBlock && !matchHit && !queueFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decRetry  <= 1'b0;
      enqStrobe <= 1'b0;
      enqIdx    <= '0;
    end else begin
      decValid  <= reqValid;
      decRetry  <= reqValid && !strb.freeHead;
      enqStrobe <= strb.enq;
      if (strb.enq) enqIdx <= tailIdx;
    end
  end

  assert_lockseq_retry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqLocked && lockSeqActive) |=> (decRetry && !enqStrobe));

  assert_buslock_retry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLocked && targetBusLocked) |=> (decRetry && !enqStrobe));

  assert_pending_retry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && matchHit && matchState != SLOT_DONE) |=> (decRetry && !enqStrobe));

  assert_not_head_retry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && matchHit && matchState == SLOT_DONE && matchIdx != headIdx)
      |=> (decRetry && !enqStrobe));

  assert_full_retry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !matchHit && queueFull) |=> (decRetry && !enqStrobe));

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeHead |=> (decValid && !decRetry));

  assert_dec_timing_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !decValid && !decRetry && !enqStrobe);
endmodule

// File: rtl/dwq_retry_arbiter.sv
module dwq_retry_arbiter
  import dwq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic              reqLocked,
  input  logic              lockSeqActive,
  input  logic              targetBusLocked,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueIdx,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspIdx,
  output logic              decValid,
  output logic              decRetry,
  output logic              enqStrobe,
  output logic [IDX_W-1:0]  enqIdx,
  output logic              complReady,
  output logic [IDX_W-1:0]  complIdx
);
  dwqStrobe_t       strb;
  logic             matchHit;
  logic [IDX_W-1:0] matchIdx;
  slotState_t       matchState;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             queueFull, headDone;

  dwq_store #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqCmd(reqCmd), .reqLocked(reqLocked),
    .issueValid(issueValid), .issueIdx(issueIdx),
    .rspValid(rspValid), .rspIdx(rspIdx),
    .matchHit(matchHit), .matchIdx(matchIdx), .matchState(matchState),
    .headIdx(headIdx), .tailIdx(tailIdx), .queueFull(queueFull), .headDone(headDone)
  );

  dwq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLocked(reqLocked),
    .lockSeqActive(lockSeqActive), .targetBusLocked(targetBusLocked),
    .matchHit(matchHit), .matchIdx(matchIdx), .matchState(matchState),
    .headIdx(headIdx), .tailIdx(tailIdx), .queueFull(queueFull),
    .strb(strb), .decValid(decValid), .decRetry(decRetry),
    .enqStrobe(enqStrobe), .enqIdx(enqIdx)
  );

  assign complReady = headDone;
  assign complIdx   = headIdx;

  assert_ready_reset_R9: assert property (@(posedge clk)
    !rstN |=> !complReady);
endmodule

// File: tb/test_dwq_retry_arbiter.sv
module test_dwq_retry_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [3:0] reqCmd = '0;
  logic reqLocked = 1'b0;
  logic lockSeqActive = 1'b0;
  logic targetBusLocked = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueIdx = '0;
  logic rspValid = 1'b0;
  logic [1:0] rspIdx = '0;
  logic decValid, decRetry, enqStrobe, complReady;
  logic [1:0] enqIdx, complIdx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench slot model: state 0 free, 1 queued, 2 issued, 3 completed
  int mAddr [DEPTH];
  int mCmd  [DEPTH];
  int mSt   [DEPTH];
  int mHead = 0;
  int mTail = 0;
  int mCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwq_retry_arbiter #(.ADDR_W(8), .CMD_W(4), .DEPTH(DEPTH)) i_dwq_retry_arbiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .reqLocked(reqLocked), .lockSeqActive(lockSeqActive), .targetBusLocked(targetBusLocked),
    .issueValid(issueValid), .issueIdx(issueIdx), .rspValid(rspValid), .rspIdx(rspIdx),
    .decValid(decValid), .decRetry(decRetry), .enqStrobe(enqStrobe), .enqIdx(enqIdx),
    .complReady(complReady), .complIdx(complIdx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkReady(input string tag);
    int expReady;
    expReady = (mCount > 0 && mSt[mHead] == 3) ? 1 : 0;
    check(complReady == expReady, tag, complReady, expReady);
    if (mCount > 0) check(complIdx == mHead, tag, complIdx, mHead);
  endtask

  task automatic doReq(input int addr, input int cmd, input bit lk);
    bit lockBlk, expRetry, expEnq;
    int hit;
    string tag;
    hit = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mSt[i] != 0 && mAddr[i] == addr && mCmd[i] == cmd) hit = i;
    lockBlk = (!lk && lockSeqActive) || (lk && targetBusLocked);
    expEnq = 0;
    expRetry = 1;
    if (lockBlk) tag = lk ? "R6" : "R5";
    else if (hit >= 0) begin
      if (mSt[hit] == 3 && hit == mHead) begin expRetry = 0; tag = "R7"; end
      else if (mSt[hit] == 3) tag = "R3";
      else tag = "R2";
    end
    else if (mCount == DEPTH) tag = "R4";
    else begin expEnq = 1; tag = "R1"; end
    reqValid = 1'b1; reqAddr = 8'(addr); reqCmd = 4'(cmd); reqLocked = lk;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check(decValid == 1'b1, {tag, " R8 valid"}, decValid, 1);
    check(decRetry == expRetry, {tag, " retry"}, decRetry, expRetry);
    check(enqStrobe == expEnq, {tag, " enqueue"}, enqStrobe, expEnq);
    if (expEnq) begin
      check(enqIdx == mTail, "R1 slot", enqIdx, mTail);
      mAddr[mTail] = addr; mCmd[mTail] = cmd; mSt[mTail] = 1;
      mTail = (mTail + 1) % DEPTH; mCount++;
    end
    if (tag == "R7") begin
      mSt[mHead] = 0; mHead = (mHead + 1) % DEPTH; mCount--;
    end
    checkReady({tag, " R11 ready"});
  endtask

  task automatic doIssue(input int idx);
    issueValid = 1'b1; issueIdx = 2'(idx);
    @(posedge clk); @(negedge clk);
    issueValid = 1'b0;
    if (mSt[idx] == 1) mSt[idx] = 2;
    checkReady("R10 issue");
  endtask

  task automatic doRsp(input int idx);
    rspValid = 1'b1; rspIdx = 2'(idx);
    @(posedge clk); @(negedge clk);
    rspValid = 1'b0;
    if (mSt[idx] == 2) mSt[idx] = 3;
    checkReady("R11 rsp");
  endtask

  task automatic drainAll();
    int h;
    lockSeqActive = 1'b0; targetBusLocked = 1'b0;
    while (mCount > 0) begin
      h = mHead;
      if (mSt[h] == 1) doIssue(h);
      if (mSt[h] == 2) doRsp(h);
      doReq(mAddr[h], mCmd[h], 1'b0);
    end
  endtask

  initial begin
    int slots [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin mSt[i] = 0; mAddr[i] = 0; mCmd[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(decValid == 0 && decRetry == 0 && enqStrobe == 0, "R9 outputs", decValid, 0);
    check(complReady == 0, "R9 ready", complReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(decValid == 0, "R8 idle", decValid, 0);

    // Lock sweep against several fill levels
    for (int fill = 0; fill < DEPTH; fill++) begin
      for (int k = 0; k < fill; k++) doReq(8'h80 + k, 1, 1'b0);
      for (int combo = 0; combo < 8; combo++) begin
        lockSeqActive = combo[1]; targetBusLocked = combo[2];
        doReq(8'h10 + combo, 2, combo[0]);
        if (mCount > 0 && mSt[mHead] == 1) doIssue(mHead);
        if (mCount > 0 && mSt[mHead] == 2) doRsp(mHead);
        doReq(mAddr[mHead], mCmd[mHead], combo[0]);
      end
      drainAll();
    end
    @(negedge clk);
    check(decValid == 0, "R8 idle after drain", decValid, 0);

    // Fill, overflow, duplicates, out-of-order responses
    for (int k = 0; k < DEPTH; k++) begin slots[k] = mTail; doReq(8'h20 + k, k, 1'b0); end
    doReq(8'h30, 5, 1'b0);                 // full: R4
    doReq(8'h21, 1, 1'b0);                 // duplicate queued: R2
    doRsp(slots[0]);                       // response to queued slot ignored: R10
    doReq(8'h20, 0, 1'b0);                 // still pending: R2
    for (int k = 0; k < DEPTH; k++) doIssue(slots[k]);
    doIssue(slots[0]);                     // second issue ignored: R10
    doReq(8'h22, 2, 1'b0);                 // issued: R2
    for (int k = DEPTH - 1; k >= 0; k--) doRsp(slots[k]);
    doReq(8'h23, 3, 1'b0);                 // completed, not oldest: R3
    targetBusLocked = 1'b1;
    doReq(8'h20, 0, 1'b1);                 // locked repeat on locked bus: R6
    targetBusLocked = 1'b0;
    lockSeqActive = 1'b1;
    doReq(8'h20, 0, 1'b0);                 // unlocked repeat during lock sequence: R5
    lockSeqActive = 1'b0;
    for (int k = 0; k < DEPTH; k++) doReq(8'h20 + k, k, 1'b0);  // in-order accepts: R7

    // Wrap rounds with same address, different commands
    for (int round = 0; round < 6; round++) begin
      for (int k = 0; k <= round % DEPTH; k++) doReq(8'h40, k + 1, 1'b0);
      drainAll();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule